// File: doc/BRIEF.md
# Prioritized UART Interrupt Controller

This block is the interrupt logic of one UART channel. It keeps a four-bit interrupt mask, which a host writes over a simple register strobe. It watches four source conditions: a receiver line error, a full receive holding register, a transmit-holding-empty event and a modem status change. When at least one unmasked source is pending it raises an interrupt request. It also presents an eight-bit status value that names the most urgent pending source.

The host services interrupts by reading the status value. The read strobe acknowledges only the source it reported, so sources of lower rank become visible on later reads. The sources do not all behave alike. Receive-ready mirrors the holding register level. Line error and modem change latch until they are acknowledged, and re-latch if their condition is still present. Transmit-empty latches on its event and stays cleared after acknowledgement until the next event arrives.

The serial shifter, FIFOs, baud logic and modem pins lie outside this block. They appear only as the level and pulse inputs described below.

Top module: `uic_ctrl`

## Requirements
- R1: After synchronous active-high reset the mask reads 0x00, the status reads 0x01 and irq_o is low.
- R2: A cycle with en_wr_i high stores wdata_i[3:0] into the mask, visible on en_rdata_o from the next cycle; en_rdata_o[7:4] always read 0.
- R3: Mask bit 0 enables receive-ready, bit 1 transmit-empty, bit 2 line error, bit 3 modem change; a masked source never affects irq_o or the status code.
- R4: Status bits [3:0] name the highest-ranked unmasked pending source: line error 0110 (highest), receive-ready 0100, transmit-empty 0010, modem change 0000 (lowest).
- R5: A cycle with stat_rd_i high clears only the source reported in that cycle; lower-ranked pending sources stay pending and appear afterwards.
- R6: irq_o is high exactly when at least one unmasked source is pending.
- R7: Receive-ready is pending in the cycle after rx_full_i is high and drops in the cycle after rx_full_i is low, without any read.
- R8: Line error and modem change latch when their input is high and hold until acknowledged; an acknowledgement while the input is still high leaves them pending.
- R9: Transmit-empty latches on a tx_empty_evt_i pulse; once acknowledged it stays cleared until the next pulse.
- R10: A source event in the same cycle as the read that acknowledges that source keeps it pending.
- R11: With nothing unmasked pending the status reads 0x01; status bits [7:4] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_wr_i | input | 1 | Mask write strobe |
| wdata_i | input | DATA_W | Mask write data |
| en_rdata_o | output | DATA_W | Mask readback |
| stat_rd_i | input | 1 | Status read strobe (acknowledge) |
| stat_rdata_o | output | DATA_W | Status value |
| line_err_i | input | 1 | Receiver line error condition |
| rx_full_i | input | 1 | Receive holding register full (level) |
| tx_empty_evt_i | input | 1 | Transmit holding register became empty (pulse) |
| modem_chg_i | input | 1 | Modem status change condition |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default DATA_W of 8, the register width that a host bus would see. At that width the always-zero upper halves of both readback values are observable. A directed part walks through a full service sequence, from line error down to modem change, and covers the acknowledge-versus-event collision and the masking of each source. A long random phase varies masks, events and reads so that every priority pairing and every acknowledge race is reached.

// File: rtl/uic_pkg.sv
package uic_pkg;

    // Sources indexed by rank: 0 is serviced first.
    localparam int unsigned NSRC   = 4;
    localparam int unsigned CODE_W = 4;

    localparam int unsigned P_LINE  = 0;
    localparam int unsigned P_RX    = 1;
    localparam int unsigned P_TX    = 2;
    localparam int unsigned P_MODEM = 3;

    localparam logic [CODE_W-1:0] CODE_NONE = 4'b0001;

    typedef enum logic [0:0] {
        KIND_FOLLOW,   // pending mirrors the input level
        KIND_LATCH     // pending holds until acknowledged
    } kind_e;

    // Status code reported for a rank.
    function automatic logic [CODE_W-1:0] prio_code(input int unsigned p);
        case (p)
            P_LINE:  return 4'b0110;
            P_RX:    return 4'b0100;
            P_TX:    return 4'b0010;
            default: return 4'b0000;
        endcase
    endfunction

    // Mask bit that gates a rank.
    function automatic int unsigned mask_bit(input int unsigned p);
        case (p)
            P_LINE:  return 2;
            P_RX:    return 0;
            P_TX:    return 1;
            default: return 3;
        endcase
    endfunction

    function automatic kind_e prio_kind(input int unsigned p);
        return (p == P_RX) ? KIND_FOLLOW : KIND_LATCH;
    endfunction

endpackage

// File: rtl/uic_src_flag.sv
module uic_src_flag #(
    parameter uic_pkg::kind_e KIND = uic_pkg::KIND_LATCH
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    typedef struct packed {
        logic pend;
    } flag_t;

    flag_t st_d, st_q;

    generate
        if (KIND == uic_pkg::KIND_FOLLOW) begin : g_follow
            logic unused_clr;
            assign unused_clr = clr_i;
            always_comb begin
                st_d      = st_q;
                st_d.pend = set_i;
            end
        end else begin : g_latch
            // a fresh set wins over a same-cycle acknowledge
            always_comb begin
                st_d      = st_q;
                st_d.pend = set_i | (st_q.pend & ~clr_i);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pend_o = st_q.pend;

endmodule

// File: rtl/uic_prio_enc.sv
module uic_prio_enc #(
    parameter int unsigned NSRC   = uic_pkg::NSRC,
    parameter int unsigned CODE_W = uic_pkg::CODE_W
) (
    input  logic [NSRC-1:0]   req_i,
    output logic [NSRC-1:0]   grant_o,
    output logic [CODE_W-1:0] code_o,
    output logic              any_o
);

    typedef struct packed {
        logic [NSRC-1:0]   grant;
        logic [CODE_W-1:0] code;
        logic              any;
    } enc_t;

    enc_t enc_d;

    always_comb begin
        enc_d.grant = '0;
        enc_d.code  = uic_pkg::CODE_NONE;
        enc_d.any   = 1'b0;
        // walk from lowest rank up so the highest rank is written last
        for (int p = int'(NSRC) - 1; p >= 0; p--) begin
            if (req_i[p]) begin
                enc_d.grant    = '0;
                enc_d.grant[p] = 1'b1;
                enc_d.code     = uic_pkg::prio_code(unsigned'(p));
                enc_d.any      = 1'b1;
            end
        end
    end

    assign grant_o = enc_d.grant;
    assign code_o  = enc_d.code;
    assign any_o   = enc_d.any;

endmodule

// File: rtl/uic_ctrl.sv
module uic_ctrl #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] en_rdata_o,
    input  logic              stat_rd_i,
    output logic [DATA_W-1:0] stat_rdata_o,
    input  logic              line_err_i,
    input  logic              rx_full_i,
    input  logic              tx_empty_evt_i,
    input  logic              modem_chg_i,
    output logic              irq_o
);

    localparam int unsigned NSRC   = uic_pkg::NSRC;
    localparam int unsigned CODE_W = uic_pkg::CODE_W;
    localparam int unsigned PAD_W  = DATA_W - CODE_W;
    localparam int unsigned EPAD_W = DATA_W - NSRC;

    typedef struct packed {
        logic [NSRC-1:0] mask;
    } regs_t;

    regs_t r_d, r_q;

    logic [NSRC-1:0]   src_by_rank;
    logic [NSRC-1:0]   mask_by_rank;
    logic [NSRC-1:0]   pend_by_rank;
    logic [NSRC-1:0]   live_by_rank;
    logic [NSRC-1:0]   grant;
    logic [NSRC-1:0]   ack_by_rank;
    logic [CODE_W-1:0] code;
    logic              any_live;
    logic [EPAD_W-1:0] unused_wdata_hi;

    assign unused_wdata_hi = wdata_i[DATA_W-1:NSRC];

    // mask register
    always_comb begin
        r_d = r_q;
        if (en_wr_i) r_d.mask = wdata_i[NSRC-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign src_by_rank[uic_pkg::P_LINE]  = line_err_i;
    assign src_by_rank[uic_pkg::P_RX]    = rx_full_i;
    assign src_by_rank[uic_pkg::P_TX]    = tx_empty_evt_i;
    assign src_by_rank[uic_pkg::P_MODEM] = modem_chg_i;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_src
            assign mask_by_rank[g] = r_q.mask[uic_pkg::mask_bit(g)];
            assign ack_by_rank[g]  = stat_rd_i & grant[g];

            uic_src_flag #(
                .KIND (uic_pkg::prio_kind(g))
            ) i_flag (
                .clk    (clk),
                .rst    (rst),
                .set_i  (src_by_rank[g]),
                .clr_i  (ack_by_rank[g]),
                .pend_o (pend_by_rank[g])
            );
        end
    endgenerate

    assign live_by_rank = pend_by_rank & mask_by_rank;

    uic_prio_enc #(
        .NSRC   (NSRC),
        .CODE_W (CODE_W)
    ) i_enc (
        .req_i   (live_by_rank),
        .grant_o (grant),
        .code_o  (code),
        .any_o   (any_live)
    );

    assign stat_rdata_o = {{PAD_W{1'b0}}, code};
    assign en_rdata_o   = {{EPAD_W{1'b0}}, r_q.mask};
    assign irq_o        = any_live;

endmodule

// File: rtl/uic_ctrl_chk.sv
module uic_ctrl_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              en_wr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] en_rdata_o,
    input logic              stat_rd_i,
    input logic [DATA_W-1:0] stat_rdata_o,
    input logic              line_err_i,
    input logic              rx_full_i,
    input logic              tx_empty_evt_i,
    input logic              modem_chg_i,
    input logic              irq_o
);

    localparam int unsigned NSRC   = uic_pkg::NSRC;
    localparam int unsigned CODE_W = uic_pkg::CODE_W;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (en_rdata_o == '0 && stat_rdata_o[CODE_W-1:0] == 4'b0001 && !irq_o));

    a_r2_mask_write: assert property (@(posedge clk) disable iff (rst)
        en_wr_i |=> en_rdata_o[NSRC-1:0] == $past(wdata_i[NSRC-1:0]));

    a_r2_mask_upper_zero: assert property (@(posedge clk) disable iff (rst)
        en_rdata_o[DATA_W-1:NSRC] == '0);

    a_r3_line_masked: assert property (@(posedge clk) disable iff (rst)
        !en_rdata_o[2] |-> stat_rdata_o[CODE_W-1:0] != 4'b0110);

    a_r6_irq_vs_status: assert property (@(posedge clk) disable iff (rst)
        irq_o == (stat_rdata_o[CODE_W-1:0] != 4'b0001));

    a_r7_rx_drops: assert property (@(posedge clk) disable iff (rst)
        !rx_full_i |=> stat_rdata_o[CODE_W-1:0] != 4'b0100);

    a_r9_tx_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (stat_rd_i && stat_rdata_o[CODE_W-1:0] == 4'b0010 && !tx_empty_evt_i)
        |=> stat_rdata_o[CODE_W-1:0] != 4'b0010);

    a_r10_tx_event_wins: assert property (@(posedge clk) disable iff (rst)
        (stat_rd_i && stat_rdata_o[CODE_W-1:0] == 4'b0010 && tx_empty_evt_i && !en_wr_i)
        |=> irq_o);

    a_r11_status_upper_zero: assert property (@(posedge clk) disable iff (rst)
        stat_rdata_o[DATA_W-1:CODE_W] == '0);

endmodule

bind uic_ctrl uic_ctrl_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_uic_ctrl.sv
`timescale 1ns/100ps
module test_uic_ctrl;

    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en_wr_i = 1'b0;
    logic [DATA_W-1:0] wdata_i = '0;
    logic [DATA_W-1:0] en_rdata_o;
    logic              stat_rd_i = 1'b0;
    logic [DATA_W-1:0] stat_rdata_o;
    logic              line_err_i = 1'b0;
    logic              rx_full_i = 1'b0;
    logic              tx_empty_evt_i = 1'b0;
    logic              modem_chg_i = 1'b0;
    logic              irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    uic_ctrl #(.DATA_W(DATA_W)) i_uic_ctrl (.*);

    // ---------------- reference model ----------------
    // m_line, m_rx, m_tx, m_modem : pending flags; m_mask : mask bits
    bit       m_line, m_rx, m_tx, m_modem;
    bit [3:0] m_mask;

    function automatic bit [7:0] model_status();
        if (m_line  && m_mask[2]) return 8'h06;
        if (m_rx    && m_mask[0]) return 8'h04;
        if (m_tx    && m_mask[1]) return 8'h02;
        if (m_modem && m_mask[3]) return 8'h00;
        return 8'h01;
    endfunction

    task automatic model_step();
        bit [7:0] s;
        s = model_status();
        if (rst) begin
            m_line = 0; m_rx = 0; m_tx = 0; m_modem = 0; m_mask = '0;
        end else begin
            m_line  = line_err_i     | (m_line  & !(stat_rd_i && s == 8'h06));
            m_tx    = tx_empty_evt_i | (m_tx    & !(stat_rd_i && s == 8'h02));
            m_modem = modem_chg_i    | (m_modem & !(stat_rd_i && s == 8'h00));
            m_rx    = rx_full_i;
            if (en_wr_i) m_mask = wdata_i[3:0];
        end
    endtask

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare_model();
        check("R4 status vs model", stat_rdata_o, model_status());
        check("R6 irq vs model", irq_o, model_status() != 8'h01);
        check("R2 mask vs model", en_rdata_o, {4'h0, m_mask});
    endtask

    // one clock: model follows the edge, outputs compared after it
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_model();
    endtask

    task automatic clear_inputs();
        en_wr_i = 0; wdata_i = '0; stat_rd_i = 0;
        line_err_i = 0; tx_empty_evt_i = 0; modem_chg_i = 0;
    endtask

    task automatic set_mask(input bit [7:0] v);
        en_wr_i = 1; wdata_i = v;
        tick();
        en_wr_i = 0; wdata_i = '0;
    endtask

    task automatic read_status();
        stat_rd_i = 1;
        tick();
        stat_rd_i = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        @(negedge clk);
        tick(); tick();
        // R1 reset state
        check("R1 status after reset", stat_rdata_o, 8'h01);
        check("R1 irq after reset", irq_o, 0);
        check("R1 mask after reset", en_rdata_o, 8'h00);
        rst = 0;
        tick();

        // R2 upper mask bits dropped
        set_mask(8'hFF);
        check("R2 mask readback", en_rdata_o, 8'h0F);

        // R7 receive-ready follows level
        rx_full_i = 1;
        tick();
        check("R7 rx pending", stat_rdata_o, 8'h04);

        // load all other sources with one-cycle pulses
        line_err_i = 1; tx_empty_evt_i = 1; modem_chg_i = 1;
        tick();
        clear_inputs();
        check("R4 line highest", stat_rdata_o, 8'h06);
        check("R6 irq high", irq_o, 1);

        // R5 service in rank order
        read_status();
        check("R5 rx after line ack", stat_rdata_o, 8'h04);
        read_status();
        check("R7 rx stays while full", stat_rdata_o, 8'h04);
        rx_full_i = 0;
        tick();
        check("R7 rx drops when empty", stat_rdata_o, 8'h02);
        read_status();
        check("R9 tx acked, modem next", stat_rdata_o, 8'h00);
        read_status();
        check("R11 nothing pending", stat_rdata_o, 8'h01);
        check("R6 irq low", irq_o, 0);

        // R9 tx stays cleared without a new event
        tick(); tick();
        check("R9 tx stays clear", stat_rdata_o, 8'h01);

        // R10 event in the acknowledging cycle stays pending
        tx_empty_evt_i = 1;
        tick();
        check("R9 tx latched", stat_rdata_o, 8'h02);
        stat_rd_i = 1;
        tick();
        clear_inputs();
        check("R10 tx kept by same-cycle event", stat_rdata_o, 8'h02);
        read_status();
        check("R10 tx cleared by later read", stat_rdata_o, 8'h01);

        // R8 modem change still asserted survives its acknowledge
        modem_chg_i = 1;
        tick();
        read_status();
        check("R8 modem re-latched", stat_rdata_o, 8'h00);
        modem_chg_i = 0;
        read_status();
        check("R8 modem cleared", stat_rdata_o, 8'h01);

        // R3 masking: only transmit-empty enabled
        line_err_i = 1; modem_chg_i = 1; rx_full_i = 1;
        tick();
        clear_inputs();
        set_mask(8'h02);
        check("R3 masked sources hidden", stat_rdata_o, 8'h01);
        check("R3 masked irq low", irq_o, 0);
        tx_empty_evt_i = 1;
        tick();
        tx_empty_evt_i = 0;
        check("R3 only tx visible", stat_rdata_o, 8'h02);
        read_status();
        check("R3 masked line not acked", stat_rdata_o, 8'h01);
        set_mask(8'h04);
        check("R3 line still pending", stat_rdata_o, 8'h06);
        rx_full_i = 0;
        set_mask(8'h0F);
        read_status();
        read_status();
        read_status();

        // random phase, model compared every cycle
        for (int i = 0; i < 4000; i++) begin
            line_err_i     = ($urandom_range(0, 9) == 0);
            rx_full_i      = ($urandom_range(0, 3) != 0) ? rx_full_i : ~rx_full_i;
            tx_empty_evt_i = ($urandom_range(0, 5) == 0);
            modem_chg_i    = ($urandom_range(0, 11) == 0);
            stat_rd_i      = ($urandom_range(0, 2) == 0);
            en_wr_i        = ($urandom_range(0, 40) == 0);
            wdata_i        = 8'($urandom);
            rst            = ($urandom_range(0, 1500) == 0);
            tick();
        end
        rst = 0;
        clear_inputs();
        tick();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule